// File: doc/BRIEF.md
# Display Line Tracker with Vertical Scroll and Line Interrupt

This block keeps count of the displayed scan line in a video display processor. A start-of-frame strobe restarts the count at line 0, and each start-of-line strobe moves it forward by one line. Every time a new visible line begins, the block forms the line address used for memory fetch. That address is the displayed line plus an 8-bit vertical scroll value, taken modulo 256. The virtual screen is therefore 256 lines tall, and a non-zero scroll wraps its top part around to the bottom of the visible picture.

The visible height is chosen by a mode bit: 192 or 212 lines. When the count would reach that height, the active-display flag drops. Further line strobes are then ignored until the next frame strobe.

A programmable compare line raises a line-hit status flag when display of the matching line begins. The interrupt request is the line-hit flag gated by an enable bit. A status read strobe clears the flag, and with it the request.

Top module: `scanline_tracker`

## Requirements
- R1: After reset, `fetch_line` is 0 and `disp_active`, `line_irq` and `line_hit` are all 0.
- R2: A `frame_start` pulse begins displayed line 0. On the next cycle `disp_active` is 1 and `fetch_line` equals `scroll_off`.
- R3: A `line_start` pulse while `disp_active` is 1 moves to displayed line n+1. On the next cycle `fetch_line` = (n+1 + `scroll_off`) mod 256, so the address wraps past 255 back to 0.
- R4: `scroll_off` is sampled only when a line begins. Changing it between line pulses leaves `fetch_line` unchanged until the next line begins.
- R5: The visible height is 192 lines when `tall_mode` is 0 and 212 lines when it is 1. A `line_start` that would reach that height clears `disp_active`, and `fetch_line` holds its last value.
- R6: While `disp_active` is 0, `line_start` pulses have no effect on `fetch_line`, `disp_active` or `line_hit` until the next `frame_start`.
- R7: When a visible line n begins and n equals `irq_line`, `line_hit` is 1 on the next cycle, whatever the value of `irq_en`.
- R8: `line_irq` is 1 exactly when `line_hit` is 1 and `irq_en` is 1.
- R9: A `stat_rd` pulse clears `line_hit`, and with it `line_irq`, on the next cycle. If a match occurs in the same cycle as the read, the match wins and `line_hit` stays 1.
- R10: When `frame_start` and `line_start` are high in the same cycle, the frame start takes priority and line 0 begins.
- R11: An `irq_line` value at or above the visible height never sets `line_hit`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_start | input | 1 | Start-of-frame strobe; begins displayed line 0 |
| line_start | input | 1 | Start-of-line strobe; moves to the next displayed line |
| scroll_off | input | 8 | Vertical scroll offset added to the displayed line |
| irq_line | input | 8 | Displayed line number that triggers the line-hit flag |
| irq_en | input | 1 | Line interrupt enable |
| tall_mode | input | 1 | 0: 192 visible lines, 1: 212 visible lines |
| stat_rd | input | 1 | Status read strobe; clears the line-hit flag |
| fetch_line | output | 8 | Virtual line address for memory fetch |
| disp_active | output | 1 | High while a visible line is being displayed |
| line_irq | output | 1 | Line interrupt request |
| line_hit | output | 1 | Line-match status flag |

## Verification
The hardest situations to reach from the ports sit at the end of a frame. A match on the last visible line (191 or 212 minus one) only occurs after a full frame of line pulses with the matching mode. The ignored pulses after the active flag drops need the same long run first. Directed passes walk complete frames in both height modes, with the compare line set to the final visible line and just past it, and with a status read landing on the match cycle. A long constrained-random run then mixes frame restarts, mode flips, scroll changes and reads against a bench model.

// File: rtl/sl_pkg.sv
package sl_pkg;

    localparam int unsigned LINE_W  = 8;
    localparam int unsigned SHORT_H = 192;
    localparam int unsigned TALL_H  = 212;
    localparam int unsigned CNT_W   = $clog2(TALL_H + 1);

    typedef logic [CNT_W-1:0]  disp_cnt_t;
    typedef logic [LINE_W-1:0] vline_t;

    // Line-start event computed by the counter and consumed by the others
    typedef struct packed {
        logic      start;   // a line begins this cycle
        logic      vis;     // that line is inside the visible height
        disp_cnt_t line;    // displayed line number that begins
    } line_evt_t;

    function automatic disp_cnt_t vis_height(input logic tall);
        return tall ? disp_cnt_t'(TALL_H) : disp_cnt_t'(SHORT_H);
    endfunction

    function automatic vline_t scroll_add(input disp_cnt_t ln, input vline_t off);
        return vline_t'(ln) + off;
    endfunction

endpackage

// File: rtl/sl_line_counter.sv
module sl_line_counter
    import sl_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      frame_start,
    input  logic      line_start,
    input  logic      tall_mode,
    output line_evt_t evt,
    output logic      active
);

    disp_cnt_t cnt_q;
    logic      act_q;
    disp_cnt_t height;

    always_comb begin
        height    = vis_height(tall_mode);
        // frame strobe wins over line strobe (R10)
        evt.start = frame_start | (line_start & act_q);
        evt.line  = frame_start ? '0 : cnt_q + disp_cnt_t'(1);
        evt.vis   = evt.line < height;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            act_q <= 1'b0;
        end else if (evt.start) begin
            if (evt.vis) begin
                cnt_q <= evt.line;
                act_q <= 1'b1;
            end else begin
                act_q <= 1'b0;
            end
        end
    end

    assign active = act_q;

    a_r2_frame_restart: assert property (@(posedge clk) disable iff (rst)
        frame_start |=> (cnt_q == '0) && act_q);

    a_r6_idle_hold: assert property (@(posedge clk) disable iff (rst)
        (!act_q && !frame_start) |=> $stable(cnt_q) && !act_q);

    a_r5_count_bound: assert property (@(posedge clk) disable iff (rst)
        cnt_q < disp_cnt_t'(TALL_H));

endmodule

// File: rtl/sl_scroll_addr.sv
module sl_scroll_addr
    import sl_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  line_evt_t evt,
    input  vline_t    scroll_off,
    output vline_t    fetch_line
);

    vline_t addr_q;

    always_ff @(posedge clk) begin
        if (rst)
            addr_q <= '0;
        else if (evt.start && evt.vis)
            addr_q <= scroll_add(evt.line, scroll_off);
    end

    assign fetch_line = addr_q;

    a_r4_hold_between_lines: assert property (@(posedge clk) disable iff (rst)
        !(evt.start && evt.vis) |=> $stable(addr_q));

endmodule

// File: rtl/sl_line_match.sv
module sl_line_match
    import sl_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  line_evt_t evt,
    input  vline_t    irq_line,
    input  logic      stat_rd,
    output logic      hit
);

    logic hit_q;
    logic match;

    always_comb
        match = evt.start && evt.vis && (evt.line == disp_cnt_t'(irq_line));

    always_ff @(posedge clk) begin
        if (rst)
            hit_q <= 1'b0;
        else if (match)
            hit_q <= 1'b1;
        else if (stat_rd)
            hit_q <= 1'b0;
    end

    assign hit = hit_q;

    a_r9_read_clears: assert property (@(posedge clk) disable iff (rst)
        (stat_rd && !match) |=> !hit_q);

    a_r7_set_needs_line: assert property (@(posedge clk) disable iff (rst)
        $rose(hit_q) |-> $past(evt.start && evt.vis));

    a_r11_below_height: assert property (@(posedge clk) disable iff (rst)
        match |-> (evt.line < disp_cnt_t'(TALL_H)));

endmodule

// File: rtl/scanline_tracker.sv
module scanline_tracker
    import sl_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        frame_start,
    input  logic        line_start,
    input  logic [7:0]  scroll_off,
    input  logic [7:0]  irq_line,
    input  logic        irq_en,
    input  logic        tall_mode,
    input  logic        stat_rd,
    output logic [7:0]  fetch_line,
    output logic        disp_active,
    output logic        line_irq,
    output logic        line_hit
);

    line_evt_t evt;

    sl_line_counter u_cnt (
        .clk         (clk),
        .rst         (rst),
        .frame_start (frame_start),
        .line_start  (line_start),
        .tall_mode   (tall_mode),
        .evt         (evt),
        .active      (disp_active)
    );

    sl_scroll_addr u_addr (
        .clk        (clk),
        .rst        (rst),
        .evt        (evt),
        .scroll_off (scroll_off),
        .fetch_line (fetch_line)
    );

    sl_line_match u_match (
        .clk      (clk),
        .rst      (rst),
        .evt      (evt),
        .irq_line (irq_line),
        .stat_rd  (stat_rd),
        .hit      (line_hit)
    );

    assign line_irq = line_hit & irq_en;

    a_r8_irq_needs_hit: assert property (@(posedge clk) disable iff (rst)
        line_irq |-> line_hit);

    a_r6_ignored_line: assert property (@(posedge clk) disable iff (rst)
        (!disp_active && !frame_start) |=> $stable(fetch_line) && !disp_active);

endmodule

// File: tb/test_scanline_tracker.sv
`timescale 1ns/1ps
module test_scanline_tracker;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       frame_start = 1'b0;
    logic       line_start = 1'b0;
    logic [7:0] scroll_off = 8'd0;
    logic [7:0] irq_line = 8'd255;
    logic       irq_en = 1'b0;
    logic       tall_mode = 1'b0;
    logic       stat_rd = 1'b0;
    logic [7:0] fetch_line;
    logic       disp_active;
    logic       line_irq;
    logic       line_hit;

    int n_cmp = 0;
    int n_bad = 0;

    // bench model state
    int   m_line = 0;
    bit   m_act  = 0;
    int   m_addr = 0;
    bit   m_hit  = 0;

    always #4 clk = ~clk;   // 125 MHz

    scanline_tracker i_scanline_tracker (
        .clk(clk), .rst(rst), .frame_start(frame_start), .line_start(line_start),
        .scroll_off(scroll_off), .irq_line(irq_line), .irq_en(irq_en),
        .tall_mode(tall_mode), .stat_rd(stat_rd), .fetch_line(fetch_line),
        .disp_active(disp_active), .line_irq(line_irq), .line_hit(line_hit)
    );

    function automatic int height_of(input bit tall);
        return tall ? 212 : 192;
    endfunction

    task automatic cmp(input string tag, input string what, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic check_all(input string tag);
        cmp(tag, "fetch_line", fetch_line, m_addr);
        cmp(tag, "disp_active", disp_active, m_act);
        cmp(tag, "line_hit", line_hit, m_hit);
        cmp(tag, "line_irq", line_irq, m_hit & irq_en);
    endtask

    // drive one cycle at the falling edge, advance the model, check after the edge
    task automatic step(input bit f, input bit l, input bit r, input string tag);
        bit start, vis, mt;
        int nl;
        frame_start = f; line_start = l; stat_rd = r;
        start = f | (l & m_act);
        nl    = f ? 0 : m_line + 1;
        vis   = nl < height_of(tall_mode);
        mt    = start && vis && (nl == int'(irq_line));
        @(posedge clk);
        if (start) begin
            if (vis) begin
                m_line = nl; m_act = 1; m_addr = (nl + int'(scroll_off)) % 256;
            end else m_act = 0;
        end
        if (mt) m_hit = 1;
        else if (r) m_hit = 0;
        @(negedge clk);
        frame_start = 0; line_start = 0; stat_rd = 0;
        check_all(tag);
    endtask

    initial begin
        #1_000_000;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'h5c0_11ed));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check_all("R1");

        // R2: frame start, scroll applied to line 0
        scroll_off = 8'd17;
        step(1, 0, 0, "R2");
        cmp("R2", "fetch_line", fetch_line, 17);

        // R3: advance and wrap past 255
        scroll_off = 8'd250;
        for (int i = 0; i < 8; i++) step(0, 1, 0, "R3");
        cmp("R3", "fetch_line wrap", fetch_line, (8 + 250) % 256);

        // R4: change scroll between line pulses
        scroll_off = 8'd3;
        @(negedge clk);
        check_all("R4");
        cmp("R4", "fetch_line held", fetch_line, (8 + 250) % 256);
        step(0, 1, 0, "R4");
        cmp("R4", "fetch_line new", fetch_line, 12);

        // R7/R8: match on the last visible short line with enable low, then high
        irq_line = 8'd191; irq_en = 1'b0;
        while (m_line < 191) step(0, 1, 0, "R3");
        cmp("R7", "line_hit at 191", line_hit, 1);
        cmp("R8", "line_irq disabled", line_irq, 0);
        irq_en = 1'b1;
        @(negedge clk);
        cmp("R8", "line_irq enabled", line_irq, 1);

        // R5: next pulse reaches 192 -> inactive, address held
        step(0, 1, 0, "R5");
        cmp("R5", "disp_active after 192", disp_active, 0);
        cmp("R5", "fetch_line held", fetch_line, (191 + 3) % 256);

        // R6: ignored pulses
        for (int i = 0; i < 5; i++) step(0, 1, 0, "R6");
        cmp("R6", "line_hit kept", line_hit, 1);

        // R9: read clears
        step(0, 0, 1, "R9");
        cmp("R9", "line_hit cleared", line_hit, 0);
        cmp("R9", "line_irq cleared", line_irq, 0);

        // R10 + tall mode: both strobes together, then run a 212-line frame
        tall_mode = 1'b1; irq_line = 8'd211; scroll_off = 8'd0;
        step(1, 1, 0, "R10");
        cmp("R10", "fetch_line line 0", fetch_line, 0);
        while (m_line < 210) step(0, 1, 0, "R5");
        // R9: read on the same cycle as the match: match wins
        step(0, 1, 1, "R9");
        cmp("R9", "match beats read", line_hit, 1);
        step(0, 1, 0, "R5");
        cmp("R5", "disp_active after 212", disp_active, 0);
        step(0, 0, 1, "R9");

        // R11: compare line past the short height never hits
        tall_mode = 1'b0; irq_line = 8'd200;
        step(1, 0, 0, "R11");
        while (m_act) step(0, 1, 0, "R11");
        cmp("R11", "no hit beyond height", line_hit, 0);

        // random phase
        for (int i = 0; i < 6000; i++) begin
            bit f, l, r;
            f = ($urandom % 300) == 0;
            l = ($urandom % 4) != 0;
            r = ($urandom % 40) == 0;
            if (($urandom % 50) == 0) scroll_off = 8'($urandom);
            if (($urandom % 400) == 0) tall_mode = 1'($urandom);
            if (($urandom % 200) == 0) irq_line = 8'($urandom % 220);
            if (($urandom % 100) == 0) irq_en = 1'($urandom);
            step(f, l, r, "R3");
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule